// File: doc/BRIEF.md
# I2C Bus Bit-Rate and Setup-Delay Generator

This block turns the system clock into the phase timing of an I2C master's SCL line. A down-counter divides the system clock by a programmable count and gives a one-cycle tick at the end of each SCL phase. Each tick carries the index of the phase that just ended. A full bus bit takes two phases in standard mode and three phases in the fast, fast-plus and high-speed modes. The bus rate is therefore f_clk / (count × phases). For example, a 48 MHz clock with count 5 in a three-phase mode gives 3.2 MHz.

One 32-bit configuration word holds two 16-bit counts. The upper half is used only in high-speed mode. The lower half serves the other three modes, so a single word can be kept for both the high-speed count and the slower-mode count. A second counter measures the data setup delay after the bus releases from clock stretching. The protocol sequencer pulses `release_evt`, then waits for `setup_done` before driving the next data bit.

Top module: `i2c_bitrate_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows `phase_tick` = 0, `phase_idx` = 0 and `setup_done` = 0.
- R2: `speed_mode` is encoded as 0 = standard, 1 = fast, 2 = high speed, 3 = fast-plus. In mode 2 the count N is `baud_cfg[31:16]`. In every other mode N is `baud_cfg[15:0]`, and the half that is not selected has no effect.
- R3: Once enabled with a stable mode, `phase_tick` is high for one cycle every N cycles. The first tick comes N cycles after the first enabled clock edge.
- R4: A selected count of 0 behaves as a count of 1, so a tick occurs on every cycle.
- R5: Ticks report `phase_idx` in the order 0,1,0,1,… in mode 0 and 0,1,2,0,… in modes 1, 2 and 3. Between ticks, `phase_idx` holds its value.
- R6: While `enable` is low there are no ticks, `phase_idx` returns to 0, and the next enabled run starts again from R3.
- R7: When `speed_mode` changes while enabled, the divider restarts: the next cycle shows no tick and `phase_idx` = 0, and the first new tick comes N cycles after the following edge.
- R8: With S = `setup_time`, `setup_done` is high for exactly one cycle, S+1 clock edges after the edge that samples `release_evt`. S = 0 waits one cycle.
- R9: A new `release_evt` while a setup delay is running restarts the delay from the new event.
- R10: While `enable` is low, `release_evt` is ignored and a running setup delay is cancelled, so `setup_done` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Runs the divider and the setup counter |
| speed_mode | input | 2 | Bus speed mode (R2 encoding) |
| baud_cfg | input | 32 | High-speed count in [31:16], other-mode count in [15:0] |
| setup_time | input | 16 | Setup delay count S |
| release_evt | input | 1 | Bus released after clock stretching |
| phase_tick | output | 1 | One-cycle pulse at the end of each SCL phase |
| phase_idx | output | 2 | Index of the phase that ended with the last tick |
| setup_done | output | 1 | One-cycle pulse when the setup delay has elapsed |

## Verification
The hardest conditions to reach are a speed-mode switch or an enable drop that lands in the middle of a count, and a second release event that arrives while a setup delay is still running. In both cases the restart must not leak a stale tick, phase index or done strobe. The directed part of the stimulus places these events at chosen points inside a count: just after a tick, mid-count, and one cycle before expiry. The random part then injects mode flips, one-cycle enable drops and dense release pulses on small counts, including zero. Because the counts are small, these collisions happen many times.

// File: rtl/i2cbr_pkg.sv
// Shared types and constants for the I2C bit-rate generator.
// Assumes a 2-bit speed-mode field whose encoding is fixed by the bus master.
package i2cbr_pkg;
    typedef enum logic [1:0] {
        SPD_STD   = 2'd0,
        SPD_FAST  = 2'd1,
        SPD_HIGH  = 2'd2,
        SPD_FPLUS = 2'd3
    } spd_mode_e;

    localparam int IDX_W       = 2;
    localparam int PHASES_STD  = 2;
    localparam int PHASES_FAST = 3;
endpackage

// File: rtl/brg_cfg_sel.sv
// Picks the active baud count from the packed configuration word by speed mode,
// maps a zero count onto one, and gives the last phase index for the mode.
// Assumes the high half of the word is the high-speed count.
module brg_cfg_sel
    import i2cbr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic [1:0]         speed_mode,
    input  logic [2*CNT_W-1:0] baud_cfg,
    output logic [CNT_W-1:0]   reload,
    output logic [IDX_W-1:0]   last_idx
);
    localparam logic [IDX_W-1:0] LAST_STD  = IDX_W'(PHASES_STD - 1);
    localparam logic [IDX_W-1:0] LAST_FAST = IDX_W'(PHASES_FAST - 1);

    logic [CNT_W-1:0] raw_cnt;

    // Choose the count half and derive the reload value (count minus one, floor at zero).
    always_comb begin
        if (spd_mode_e'(speed_mode) == SPD_HIGH) raw_cnt = baud_cfg[2*CNT_W-1:CNT_W];
        else                                     raw_cnt = baud_cfg[CNT_W-1:0];
        reload = (raw_cnt == '0) ? '0 : raw_cnt - 1'b1;
    end

    // Two phases per bit in standard mode, three in every faster mode.
    always_comb begin
        last_idx = (spd_mode_e'(speed_mode) == SPD_STD) ? LAST_STD : LAST_FAST;
    end
endmodule

// File: rtl/brg_phase_ctr.sv
// SCL phase divider: counts down from the reload value, emits a one-cycle
// tick at zero and steps the phase index. It restarts when disabled or when
// the speed mode changes. Assumes reload and last_idx are stable while it runs.
module brg_phase_ctr
    import i2cbr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [1:0]       speed_mode,
    input  logic [CNT_W-1:0] reload,
    input  logic [IDX_W-1:0] last_idx,
    output logic             tick,
    output logic [IDX_W-1:0] idx
);
    logic [CNT_W-1:0] cnt_q;
    logic [IDX_W-1:0] cur_idx;
    logic [IDX_W-1:0] idx_q;
    logic [1:0]       mode_q;
    logic             tick_q;
    logic             restart;

    // Restart on disable or whenever the mode differs from the previous cycle.
    always_comb begin
        restart = !enable || (speed_mode != mode_q);
    end

    // Down-counter, tick strobe and phase index sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            cur_idx <= '0;
            idx_q   <= '0;
            mode_q  <= '0;
            tick_q  <= 1'b0;
        end else begin
            mode_q <= speed_mode;
            if (restart) begin
                cnt_q   <= reload;
                cur_idx <= '0;
                idx_q   <= '0;
                tick_q  <= 1'b0;
            end else if (cnt_q == '0) begin
                cnt_q   <= reload;
                tick_q  <= 1'b1;
                idx_q   <= cur_idx;
                cur_idx <= (cur_idx >= last_idx) ? '0 : cur_idx + 1'b1;
            end else begin
                cnt_q  <= cnt_q - 1'b1;
                tick_q <= 1'b0;
            end
        end
    end

    assign tick = tick_q;
    assign idx  = idx_q;

    AST_NO_TICK_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !tick_q); // R6
    AST_STD_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 2'd0) |-> (cur_idx <= 2'd1)); // R5
    AST_IDX_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q <= 2'd2); // R5
    AST_MODE_SWITCH_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && speed_mode != mode_q) |=> (!tick_q && cur_idx == '0)); // R7
endmodule

// File: rtl/brg_setup_ctr.sv
// Setup-delay counter: a release-after-stretch event loads the count, and a
// one-cycle done strobe follows count+1 edges later. A new event restarts the
// delay and disable cancels it. Assumes setup_time is stable while busy.
module brg_setup_ctr #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             release_evt,
    input  logic [CNT_W-1:0] setup_time,
    output logic             done
);
    logic [CNT_W-1:0] scnt_q;
    logic             busy_q;
    logic             done_q;

    // Load on event, count down while busy, strobe done on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scnt_q <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else if (!enable) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else if (release_evt) begin
            scnt_q <= setup_time;
            busy_q <= 1'b1;
            done_q <= 1'b0;
        end else if (busy_q) begin
            if (scnt_q == '0) begin
                busy_q <= 1'b0;
                done_q <= 1'b1;
            end else begin
                scnt_q <= scnt_q - 1'b1;
                done_q <= 1'b0;
            end
        end else begin
            done_q <= 1'b0;
        end
    end

    assign done = done_q;

    AST_DONE_FOLLOWS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> $past(busy_q)); // R8
    AST_DONE_QUIET_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !done_q); // R10
    AST_RETRIGGER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && release_evt) |=> (busy_q && !done_q)); // R9
endmodule

// File: rtl/i2c_bitrate_gen.sv
// Top of the I2C bit-rate generator: selects the baud count by speed mode,
// runs the SCL phase divider and the post-stretch setup counter.
// Assumes synchronous inputs in the clk domain.
module i2c_bitrate_gen
    import i2cbr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic [1:0]         speed_mode,
    input  logic [2*CNT_W-1:0] baud_cfg,
    input  logic [CNT_W-1:0]   setup_time,
    input  logic               release_evt,
    output logic               phase_tick,
    output logic [IDX_W-1:0]   phase_idx,
    output logic               setup_done
);
    logic [CNT_W-1:0] reload;
    logic [IDX_W-1:0] last_idx;

    brg_cfg_sel #(.CNT_W(CNT_W)) u_sel (
        .speed_mode (speed_mode),
        .baud_cfg   (baud_cfg),
        .reload     (reload),
        .last_idx   (last_idx)
    );

    brg_phase_ctr #(.CNT_W(CNT_W)) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .speed_mode (speed_mode),
        .reload     (reload),
        .last_idx   (last_idx),
        .tick       (phase_tick),
        .idx        (phase_idx)
    );

    brg_setup_ctr #(.CNT_W(CNT_W)) u_setup (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .release_evt (release_evt),
        .setup_time  (setup_time),
        .done        (setup_done)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!phase_tick && !setup_done && phase_idx == '0)); // R1
endmodule

// File: tb/sim_i2c_bitrate_gen.sv
`timescale 1ns/1ps
module sim_i2c_bitrate_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [1:0]  speed_mode = 2'd0;
    logic [31:0] baud_cfg = 32'd0;
    logic [15:0] setup_time = 16'd0;
    logic        release_evt = 1'b0;
    logic        phase_tick;
    logic [1:0]  phase_idx;
    logic        setup_done;

    int    n_vec = 0;
    int    n_bad = 0;
    string tag   = "R1";
    string tag_s = "R1";

    always #2.5 clk = ~clk;

    i2c_bitrate_gen u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .speed_mode(speed_mode),
        .baud_cfg(baud_cfg), .setup_time(setup_time), .release_evt(release_evt),
        .phase_tick(phase_tick), .phase_idx(phase_idx), .setup_done(setup_done)
    );

    // Expected divide count per R2/R4.
    function automatic int exp_count(logic [1:0] m, logic [31:0] b);
        int v;
        v = (m == 2'd2) ? int'(b[31:16]) : int'(b[15:0]);
        return (v == 0) ? 1 : v;
    endfunction

    // Expected phases per bit per R5.
    function automatic int exp_phases(logic [1:0] m);
        return (m == 2'd0) ? 2 : 3;
    endfunction

    // Reference behaviour built from the requirements.
    int         m_age = 0;
    logic [1:0] m_prev = 2'd0;
    logic       m_tick = 1'b0;
    int         m_idx = 0;
    logic       m_sd = 1'b0;
    logic       m_pend = 1'b0;
    int         m_rem = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_age <= 0; m_prev <= 2'd0; m_tick <= 1'b0; m_idx <= 0;
            m_sd <= 1'b0; m_pend <= 1'b0; m_rem <= 0;
        end else begin
            m_prev <= speed_mode;
            if (!enable || speed_mode != m_prev) begin
                m_age <= 0; m_tick <= 1'b0; m_idx <= 0;
            end else begin
                int a, n;
                a = m_age + 1;
                n = exp_count(speed_mode, baud_cfg);
                m_age <= a;
                if (a % n == 0) begin
                    m_tick <= 1'b1;
                    m_idx  <= ((a / n) - 1) % exp_phases(speed_mode);
                end else begin
                    m_tick <= 1'b0;
                end
            end
            if (!enable) begin
                m_pend <= 1'b0; m_sd <= 1'b0;
            end else if (release_evt) begin
                m_pend <= 1'b1; m_rem <= int'(setup_time); m_sd <= 1'b0;
            end else if (m_pend) begin
                if (m_rem == 0) begin m_sd <= 1'b1; m_pend <= 1'b0; end
                else begin m_rem <= m_rem - 1; m_sd <= 1'b0; end
            end else begin
                m_sd <= 1'b0;
            end
        end
    end

    // One compare point per cycle, at the falling edge.
    task automatic step();
        @(negedge clk);
        n_vec++;
        if (phase_tick !== m_tick || phase_idx !== 2'(m_idx)) begin
            n_bad++;
            $display("FAIL %s tick/idx act=%0b/%0d exp=%0b/%0d at %0t",
                     tag, phase_tick, phase_idx, m_tick, m_idx, $time);
        end
        if (setup_done !== m_sd) begin
            n_bad++;
            $display("FAIL %s setup_done act=%0b exp=%0b at %0t",
                     tag_s, setup_done, m_sd, $time);
        end
    endtask

    task automatic cyc(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic pulse_release();
        release_evt = 1'b1; cyc(1); release_evt = 1'b0;
    endtask

    task automatic configure(logic [1:0] m, logic [31:0] b, logic [15:0] s);
        enable = 1'b0; cyc(2);
        speed_mode = m; baud_cfg = b; setup_time = s; cyc(2);
        enable = 1'b1;
    endtask

    initial begin
        void'($urandom(32'd4242));
        // R1: reset state
        tag = "R1"; tag_s = "R1";
        cyc(4);
        rst_n = 1'b1;
        cyc(2);
        // R3: standard mode, count 3; R5 two-phase order
        tag = "R3"; configure(2'd0, 32'h0009_0003, 16'd0); cyc(30);
        tag = "R5"; cyc(12);
        // R2: high-speed picks the upper half
        tag = "R2"; configure(2'd2, 32'h0002_0007, 16'd0); cyc(30);
        // R2: fast mode picks the lower half
        configure(2'd1, 32'h0005_0002, 16'd0); cyc(30);
        // R4: zero count means one, fast-plus
        tag = "R4"; configure(2'd3, 32'h0004_0000, 16'd0); cyc(12);
        configure(2'd2, 32'h0000_0009, 16'd0); cyc(12);
        // R7: mode change mid-count and right after a tick
        tag = "R7"; configure(2'd1, 32'h0003_0004, 16'd0); cyc(9);
        speed_mode = 2'd2; cyc(20);
        speed_mode = 2'd0; cyc(7);
        speed_mode = 2'd3; cyc(20);
        // R6: disable mid-count, then resume
        tag = "R6"; configure(2'd1, 32'h0000_0005, 16'd0); cyc(13);
        enable = 1'b0; cyc(6); enable = 1'b1; cyc(25);
        // R8: setup delay S=0 and S=5
        tag = "R3"; tag_s = "R8";
        configure(2'd0, 32'h0000_0002, 16'd0); cyc(2);
        pulse_release(); cyc(4);
        setup_time = 16'd5; pulse_release(); cyc(9);
        // R9: retrigger while counting
        tag_s = "R9"; setup_time = 16'd4;
        pulse_release(); cyc(2); pulse_release(); cyc(3); pulse_release(); cyc(8);
        // R10: release while disabled, cancel while counting
        tag_s = "R10";
        enable = 1'b0; pulse_release(); cyc(8);
        enable = 1'b1; pulse_release(); cyc(2);
        enable = 1'b0; cyc(8); enable = 1'b1; cyc(4);
        // Random segments
        tag = "R3"; tag_s = "R8";
        for (int seg = 0; seg < 40; seg++) begin
            int len;
            configure(2'($urandom % 4),
                      {16'($urandom % 7), 16'($urandom % 7)},
                      16'($urandom % 6));
            len = 20 + int'($urandom % 40);
            for (int c = 0; c < len; c++) begin
                if ($urandom % 8 == 0) release_evt = 1'b1;
                if ($urandom % 40 == 0) speed_mode = 2'($urandom % 4);
                if ($urandom % 60 == 0) enable = 1'b0;
                step();
                release_evt = 1'b0;
                enable = 1'b1;
            end
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule